// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Arbitration

This block is a synchronous 2048 x 8 memory with two independent ports, left and right. Each port has its own active-low enable, a read/write select (high reads, low writes) and an active-low output enable. When both ports reach the same location, the block decides which port owns that location and raises a registered, active-low busy flag toward the other port. A write from the port that lost is dropped. The winner is the port whose access was already in place first. When both accesses start in the same clock, the left port wins.

The busy flag is asserted from the same clock edge at which the write is refused. It stays asserted for as long as the collision lasts. While a port is busy, its read data is held, so it cannot observe a location that is changing under it. A `slave_mode` input lets several of these blocks be placed side by side to build a wider word. In that mode the block does no arbitration of its own. Each port instead takes an external busy input that blocks its writes, so one arbitrating instance can govern the others.

Top module: `dpr_collide_ram`

## Requirements
- R1: A port with enable low and read/write low stores its write data at its address on the clock edge. A port with enable low and read/write high returns, one cycle after the edge, the word that the addressed location held before that edge. The address is 11 bits wide and the word is 8 bits wide.
- R2: Read-data-valid is high in the cycle after an edge at which the port was enabled, reading, and had output enable low; otherwise it is low. Output enable has no effect on the read data itself or on the memory.
- R3: A collision exists only when both enables are low and both addresses are equal. A port whose enable is high makes no access and never causes busy on the other port. Both busy flags are high in the cycle after any edge at which there was no collision.
- R4: When a collision starts and exactly one port had the same enable-low access (same address) in the previous cycle, that port wins. This covers both orders: the enable arriving on an already matching address, and one port's address moving onto the other's.
- R5: When a collision starts and neither port, or both ports, already held it, the left port wins.
- R6: The loser's busy flag goes low after the edge at which the collision is resolved. It stays low, with the same winner, for as long as the collision continues, including when both addresses move together. Both flags are never low at the same time.
- R7: A write from the losing port is dropped. A write from the winning port is stored.
- R8: The losing port's read data does not change while it is losing. Normal reads resume once the collision ends through an address change or the enable going high.
- R9: With `slave_mode` high, both busy outputs stay high and no arbitration takes place. A write is dropped when that port's busy input is low and performed when it is high. Reads are not affected by the busy inputs.
- R10: While reset is low at a clock edge, both busy flags go high, both valid flags go low and both read-data outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | High: busy inputs gate writes and no arbitration is done |
| l_ce_n | input | 1 | Left enable, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low, gates valid only |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_busy_in_n | input | 1 | Left external busy, used in slave mode |
| l_busy_n | output | 1 | Left busy flag, active low, registered |
| l_rdata | output | 8 | Left read data, registered |
| l_rvalid | output | 1 | Left read-data valid |
| r_ce_n | input | 1 | Right enable, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_busy_in_n | input | 1 | Right external busy, used in slave mode |
| r_busy_n | output | 1 | Right busy flag, active low, registered |
| r_rdata | output | 8 | Right read data, registered |
| r_rvalid | output | 1 | Right read-data valid |

## Verification
A stale or wrongly held owner shows up one cycle later as a busy flag on the wrong side, or as a flag that outlives the collision. A lost write, or a write that should have been refused but was let through, stays hidden until that location is read back. For that reason every refused write is followed by a read of the same address. A read port that fails to freeze is visible in the very next cycle, because the winner writes new data into the location the loser is reading.

// File: rtl/dpr_pkg.sv
// Shared types for the collision-arbitrated dual-port memory.
package dpr_pkg;
    // Which port currently owns a contested location.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpr_storage.sv
// Storage array with two write ports and two combinational read taps.
// Assumes the arbiter never enables both writes to one address at once.
module dpr_storage #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    input  logic              we_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] word_l,
    output logic [DATA_W-1:0] word_r
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Apply the granted writes of both ports.
    always_ff @(posedge clk) begin
        if (we_l) cells[addr_l] <= wdata_l;
        if (we_r) cells[addr_r] <= wdata_r;
    end

    // Present the pre-edge contents at each port address.
    always_comb begin
        word_l = cells[addr_l];
        word_r = cells[addr_r];
    end
endmodule

// File: rtl/dpr_arbiter.sv
// Same-address collision arbiter. It decides ownership from this cycle's
// accesses and the accesses seen in the previous cycle. Earlier arrival
// wins and a tie goes to the left port. The lose outputs are
// combinational; the busy flags are their registered, inverted copies.
module dpr_arbiter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              act_l,
    input  logic              act_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              lose_l,
    output logic              lose_r,
    output logic              busy_l_n,
    output logic              busy_r_n
);
    import dpr_pkg::*;

    owner_e            owner_q, owner_nx;
    logic              prev_act_l, prev_act_r;
    logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
    logic              match, held_l, held_r;

    // Detect a collision and whether each side already held its access.
    always_comb begin
        match  = act_l && act_r && (addr_l == addr_r) && !slave_mode;
        held_l = prev_act_l && (prev_addr_l == addr_l);
        held_r = prev_act_r && (prev_addr_r == addr_r);
    end

    // Choose the owner: keep it while the collision lasts, else resolve.
    always_comb begin
        if (!match)                   owner_nx = OWN_NONE;
        else if (owner_q != OWN_NONE) owner_nx = owner_q;
        else if (held_r && !held_l)   owner_nx = OWN_RIGHT;
        else                          owner_nx = OWN_LEFT;
        lose_l = (owner_nx == OWN_RIGHT);
        lose_r = (owner_nx == OWN_LEFT);
    end

    // Register the owner, the busy flags and the previous-cycle accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q     <= OWN_NONE;
            busy_l_n    <= 1'b1;
            busy_r_n    <= 1'b1;
            prev_act_l  <= 1'b0;
            prev_act_r  <= 1'b0;
            prev_addr_l <= '0;
            prev_addr_r <= '0;
        end else begin
            owner_q     <= owner_nx;
            busy_l_n    <= !lose_l;
            busy_r_n    <= !lose_r;
            prev_act_l  <= act_l;
            prev_act_r  <= act_r;
            prev_addr_l <= addr_l;
            prev_addr_r <= addr_r;
        end
    end
endmodule

// File: rtl/dpr_read_port.sv
// Registered read stage for one port. The data is captured on a read
// unless the port is held by a lost collision. Valid also requires the
// output enable.
module dpr_read_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              hold,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    // Capture the read word and the valid qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            if (rd_en && !hold) rdata <= word;
            rvalid <= rd_en && !oe_n;
        end
    end
endmodule

// File: rtl/dpr_collide_ram.sv
// Top level: a 2K x 8 dual-port memory with same-address arbitration and
// write gating, plus a slave mode in which external busy inputs gate the
// writes. Assumes synchronous inputs that are stable around the rising edge.
module dpr_collide_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in_n,
    output logic              l_busy_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in_n,
    output logic              r_busy_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);
    logic              act_l, act_r, lose_l, lose_r, we_l, we_r;
    logic [DATA_W-1:0] word_l, word_r;

    // Form access and write-grant terms for both ports.
    always_comb begin
        act_l = !l_ce_n;
        act_r = !r_ce_n;
        we_l  = act_l && !l_rw_n && !lose_l && (!slave_mode || l_busy_in_n);
        we_r  = act_r && !r_rw_n && !lose_r && (!slave_mode || r_busy_in_n);
    end

    dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .act_l(act_l), .act_r(act_r), .addr_l(l_addr), .addr_r(r_addr),
        .lose_l(lose_l), .lose_r(lose_r),
        .busy_l_n(l_busy_n), .busy_r_n(r_busy_n)
    );

    dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk),
        .we_l(we_l), .addr_l(l_addr), .wdata_l(l_wdata),
        .we_r(we_r), .addr_r(r_addr), .wdata_r(r_wdata),
        .word_l(word_l), .word_r(word_r)
    );

    dpr_read_port #(.DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(act_l && l_rw_n), .hold(lose_l),
        .oe_n(l_oe_n), .word(word_l), .rdata(l_rdata), .rvalid(l_rvalid)
    );

    dpr_read_port #(.DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(act_r && r_rw_n), .hold(lose_r),
        .oe_n(r_oe_n), .word(word_r), .rdata(r_rdata), .rvalid(r_rvalid)
    );
endmodule

// File: rtl/dpr_collide_ram_chk.sv
// Property checker for dpr_collide_ram, attached by the bind below.
// It observes the ports and the internal write grants only.
module dpr_collide_ram_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              l_ce_n,
    input logic              r_ce_n,
    input logic              l_oe_n,
    input logic              r_oe_n,
    input logic              l_rw_n,
    input logic              r_rw_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic [DATA_W-1:0] l_rdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic              l_rvalid,
    input logic              r_rvalid,
    input logic              we_l,
    input logic              we_r
);
    logic still_hit;
    assign still_hit = !l_ce_n && !r_ce_n && (l_addr == r_addr) && !slave_mode;

    p_busy_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    p_disabled_left_no_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        l_ce_n |=> r_busy_n);

    p_disabled_right_no_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_ce_n |=> l_busy_n);

    p_mismatch_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_addr != r_addr) |=> (l_busy_n && r_busy_n));

    p_owner_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (still_hit && !r_busy_n) |=> !r_busy_n);

    p_loser_write_blocked_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (still_hit && !l_busy_n) |-> !we_l);

    p_loser_write_blocked_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (still_hit && !r_busy_n) |-> !we_r);

    p_loser_read_frozen_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (still_hit && !l_busy_n) |=> $stable(l_rdata));

    p_loser_read_frozen_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (still_hit && !r_busy_n) |=> $stable(r_rdata));

    p_valid_needs_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n || l_oe_n || !l_rw_n) |=> !l_rvalid);

    p_valid_needs_oe_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce_n || r_oe_n || !r_rw_n) |=> !r_rvalid);

    p_slave_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |=> (l_busy_n && r_busy_n));
endmodule

bind dpr_collide_ram dpr_collide_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpr_collide_ram_test.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model stepped once per clock and
// compared against every output of the design.
module dpr_collide_ram_test;
    localparam int AW = 11;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1, l_busy_in_n = 1'b1;
    logic r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1, r_busy_in_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic l_busy_n, r_busy_n, l_rvalid, r_rvalid;
    logic [DW-1:0] l_rdata, r_rdata;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [DW-1:0] mdl_mem [int];
    int m_owner = 0;
    bit m_pal = 0, m_par = 0;
    int m_pa_l = 0, m_pa_r = 0;
    bit e_bl = 1, e_br = 1, e_vl = 0, e_vr = 0, e_kl = 1, e_kr = 1;
    logic [DW-1:0] e_dl = '0, e_dr = '0;

    always #2 clk = ~clk;

    dpr_collide_ram uut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_busy_in_n(l_busy_in_n), .l_busy_n(l_busy_n),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_busy_in_n(r_busy_in_n), .r_busy_n(r_busy_n),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic setl(input bit ce, input bit rw, input bit oe, input int a, input int d);
        l_ce_n = ce; l_rw_n = rw; l_oe_n = oe; l_addr = a[AW-1:0]; l_wdata = d[DW-1:0];
    endtask

    task automatic setr(input bit ce, input bit rw, input bit oe, input int a, input int d);
        r_ce_n = ce; r_rw_n = rw; r_oe_n = oe; r_addr = a[AW-1:0]; r_wdata = d[DW-1:0];
    endtask

    // Advance the model by one edge, then compare after the edge.
    task automatic tick(input string tag);
        bit al, ar, hit, lh, rh, lsl, lsr;
        int ia, ib;
        if (!rst_n) begin
            m_owner = 0; m_pal = 0; m_par = 0; m_pa_l = 0; m_pa_r = 0;
            e_bl = 1; e_br = 1; e_vl = 0; e_vr = 0;
            e_dl = '0; e_dr = '0; e_kl = 1; e_kr = 1;
        end else begin
            ia = int'(l_addr); ib = int'(r_addr);
            al = !l_ce_n; ar = !r_ce_n;
            hit = al && ar && (ia == ib) && !slave_mode;
            lh = m_pal && (m_pa_l == ia);
            rh = m_par && (m_pa_r == ib);
            if (!hit) m_owner = 0;
            else if (m_owner == 0) m_owner = (rh && !lh) ? 2 : 1;
            lsl = (m_owner == 2);
            lsr = (m_owner == 1);
            if (al && l_rw_n && !lsl) begin
                e_kl = mdl_mem.exists(ia);
                if (e_kl) e_dl = mdl_mem[ia];
            end
            if (ar && r_rw_n && !lsr) begin
                e_kr = mdl_mem.exists(ib);
                if (e_kr) e_dr = mdl_mem[ib];
            end
            e_vl = al && l_rw_n && !l_oe_n;
            e_vr = ar && r_rw_n && !r_oe_n;
            if (al && !l_rw_n && !lsl && (!slave_mode || l_busy_in_n)) mdl_mem[ia] = l_wdata;
            if (ar && !r_rw_n && !lsr && (!slave_mode || r_busy_in_n)) mdl_mem[ib] = r_wdata;
            e_bl = !lsl; e_br = !lsr;
            m_pal = al; m_par = ar; m_pa_l = ia; m_pa_r = ib;
        end
        @(posedge clk);
        #1;
        chk(tag, "l_busy_n", int'(l_busy_n), int'(e_bl));
        chk(tag, "r_busy_n", int'(r_busy_n), int'(e_br));
        chk(tag, "l_rvalid", int'(l_rvalid), int'(e_vl));
        chk(tag, "r_rvalid", int'(r_rvalid), int'(e_vr));
        if (e_kl) chk(tag, "l_rdata", int'(l_rdata), int'(e_dl));
        if (e_kr) chk(tag, "r_rdata", int'(r_rdata), int'(e_dr));
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(50000 * 4);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: reset state
        tick("R10"); tick("R10");
        rst_n = 1'b1;
        tick("R10");
        // R1: writes on both ports, then crossed reads
        setl(0, 0, 1, 5, 'hA5); setr(0, 0, 1, 'h7FF, 'h3C); tick("R1");
        setl(0, 0, 1, 0, 'h5A); setr(1, 1, 1, 0, 0);        tick("R1");
        setl(0, 1, 0, 'h7FF, 0); setr(0, 1, 0, 5, 0);       tick("R1");
        setl(0, 1, 0, 0, 0); setr(1, 1, 1, 0, 0);           tick("R1");
        // R2: output enable gates only valid
        setl(0, 1, 1, 5, 0);                                tick("R2");
        setl(0, 1, 0, 0, 0);                                tick("R2");
        // R3: disabled port never collides; different addresses never collide
        setl(1, 0, 1, 9, 'h77); setr(0, 1, 0, 9, 0);        tick("R3");
        tick("R3");
        setl(0, 1, 0, 5, 0); setr(0, 1, 0, 0, 0);           tick("R3");
        setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0);           tick("R3");
        // R4: enable arbitration, left already on the address
        setl(0, 1, 0, 20, 0);                               tick("R4");
        setr(0, 0, 1, 20, 'h11);                            tick("R4");
        // R7/R8: winner writes, loser read stays frozen
        setl(0, 0, 1, 20, 'h22); setr(0, 1, 0, 20, 0);      tick("R7");
        tick("R8"); tick("R8");
        setr(1, 1, 1, 0, 0);                                tick("R8");
        setl(1, 1, 1, 0, 0); setr(0, 1, 0, 20, 0);          tick("R8");
        tick("R7");
        // R4: address arbitration, left moves onto the right's address
        setl(0, 1, 0, 40, 0); setr(0, 0, 1, 41, 'h66);      tick("R4");
        setr(0, 1, 0, 41, 0);                               tick("R4");
        setl(0, 0, 1, 41, 'h99);                            tick("R4");
        tick("R7");
        setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0);           tick("R4");
        setl(0, 1, 0, 41, 0);                               tick("R7");
        // R5: simultaneous start, left wins
        setl(1, 1, 1, 0, 0);                                tick("R5");
        setl(0, 0, 1, 50, 'h12); setr(0, 0, 1, 50, 'h34);   tick("R5");
        setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0);           tick("R5");
        setr(0, 1, 0, 50, 0);                               tick("R5");
        // R6: owner held while the collision lasts, even across a joint move
        setr(1, 1, 1, 0, 0);                                tick("R6");
        setl(0, 1, 0, 60, 0); setr(0, 1, 0, 60, 0);         tick("R6");
        setl(0, 0, 1, 60, 'h61);                            tick("R6");
        setl(0, 1, 1, 60, 0);                               tick("R6");
        setl(0, 1, 0, 61, 0); setr(0, 0, 1, 61, 'h62);      tick("R6");
        tick("R6");
        setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0);           tick("R6");
        // R9: slave mode, external busy gates writes, no own busy
        setl(0, 0, 1, 70, 'h01);                            tick("R9");
        setl(1, 1, 1, 0, 0);                                tick("R9");
        slave_mode = 1'b1;
        l_busy_in_n = 1'b0;
        setl(0, 0, 1, 70, 'hAB); setr(0, 0, 1, 71, 'hCD);   tick("R9");
        setl(0, 1, 0, 71, 0); setr(0, 1, 0, 71, 0);         tick("R9");
        setl(0, 1, 0, 70, 0); setr(0, 1, 0, 70, 0);         tick("R9");
        l_busy_in_n = 1'b1;
        setl(0, 0, 1, 72, 'hEE); setr(1, 1, 1, 0, 0);       tick("R9");
        r_busy_in_n = 1'b0;
        setl(1, 1, 1, 0, 0); setr(0, 1, 0, 72, 0);          tick("R9");
        setr(1, 1, 1, 0, 0);                                tick("R9");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule